// File: doc/BRIEF.md
# Double-Word Load Hazard Interlock

This block sits in the issue stage of an in-order 32-bit load/store pipeline. It receives one decoded instruction descriptor per cycle. The descriptor holds an operation class, up to two operand registers, a named data register and the low bits of the effective address. From it the block decides whether the instruction may leave the issue stage this cycle. It keeps a per-register countdown of the time left until an in-flight load result becomes readable. A double-word load fills two consecutive registers, and the second of them is readable one cycle after the first. A double-word load also blocks the memory port for the cycle that follows it. Multi-cycle operations occupy the issue slot for their full length.

The upstream stage holds the descriptor steady while `stall` is high. An instruction is taken when it is valid, `stall` is low and `fault` is low. When `fault` is high, the instruction is rejected and leaves no trace, and upstream drops it. A load that misses the data cache leaves both its destination registers pending. They stay pending until the memory system pulses `ld_done`.

Top module: `ldd_hazard_interlock`

## Requirements
- R1: When a double-word load with named register Rd hits and is taken in cycle t, an instruction reading Rd presented in cycle t+1 stalls for exactly 2 cycles.
- R2: In the same situation, an instruction reading Rd+1 presented in cycle t+1 stalls for exactly 3 cycles.
- R3: Any memory operation (op 1 to 6) presented in the cycle directly after a taken double-word load stalls for exactly 1 cycle, even with no register dependency. A non-memory operation in that cycle does not stall.
- R4: A double-word load or store whose effective address has nonzero low 3 bits raises `fault` and is not taken. It leaves no scoreboard entry and no memory-port bubble.
- R5: A double-word load or store whose named register is odd raises `fault` and is not taken. Single-word operations never raise `fault`.
- R6: Op encoding: 0 ALU, 1 single load, 2 single store, 3 double load, 4 double store, 5 load-multiple, 6 store-multiple, 7 no-op. `issue_cycles` is 0 without a valid instruction. Otherwise it is 1 for ops 0, 1, 2, 3 and 7, 2 for op 4, and 4 for ops 5 and 6. A taken instruction of N cycles stalls the following N-1 cycles.
- R7: A double-word load whose named register is 12 reports `issue_cycles` = 2 and stalls the next cycle.
- R8: A load taken with `in_dhit` low leaves all its destination registers pending. They become readable in the cycle after an `ld_done` pulse and not before.
- R9: A single store reads its named register, and a double-word store reads Rd and Rd+1. Either one stalls while those registers are not ready.
- R10: A single load that hits and is taken in cycle t makes its destination readable from cycle t+3.
- R11: After reset, no register is pending, `stall` and `fault` are low, and the first instruction is taken without a stall.
- R12: The memory-port bubble and the extra issue cycle of a double-word load to register 12 fall in the same cycle. A memory operation following such a load stalls for 1 cycle, not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Descriptor valid |
| in_op | input | 3 | Operation class (R6 encoding) |
| in_rd | input | REG_W | Named data register: destination for loads, data source for stores |
| in_src_a | input | REG_W | First operand / base register |
| in_src_a_en | input | 1 | First operand is read |
| in_src_b | input | REG_W | Second operand register |
| in_src_b_en | input | 1 | Second operand is read |
| in_ea_low | input | ALIGN_W | Low bits of the effective address |
| in_dhit | input | 1 | Data-cache hit for a load |
| ld_done | input | 1 | Pending miss data has arrived |
| stall | output | 1 | Hold the presented instruction |
| issue_cycles | output | IC_W | Issue-slot cycles of the presented instruction |
| fault | output | 1 | Misaligned address or odd register on a double-word access |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, the memory-port bubble after a double-word load lands in the same cycle as that load's extra issue cycle when its named register is 12. The bench provokes this by putting a single load straight after such a load. In the second pair, the bubble coincides with a register dependency when a double-word store reads the pair just loaded. In both cases the bench measures how many cycles the follower is held, and the stall must be the longer of the two causes, not their sum. A behavioural reference built on ready-cycle numbers judges `stall`, `fault` and `issue_cycles` on every clock.

// File: rtl/ldd_pkg.sv
`timescale 1ns/1ps
package ldd_pkg;
  typedef enum logic [2:0] {
    OP_ALU  = 3'd0,
    OP_LDR  = 3'd1,
    OP_STR  = 3'd2,
    OP_LDRD = 3'd3,
    OP_STRD = 3'd4,
    OP_LDM  = 3'd5,
    OP_STM  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;
endpackage

// File: rtl/ldd_decode.sv
`timescale 1ns/1ps
module ldd_decode #(
  parameter int NREG       = 16,
  parameter int CNT_W      = 3,
  parameter int LAT_EVEN   = 3,
  parameter int LAT_ODD    = 4,
  parameter int LAT_SINGLE = 3,
  parameter int WIDE_REG   = 12,
  parameter int MULTI_CYC  = 4,
  parameter int REG_W      = 4,
  parameter int ALIGN_W    = 3,
  parameter int IC_W       = 3
) (
  input  logic [2:0]         op_raw,
  input  logic [REG_W-1:0]   rd,
  input  logic [REG_W-1:0]   src_a,
  input  logic               src_a_en,
  input  logic [REG_W-1:0]   src_b,
  input  logic               src_b_en,
  input  logic [ALIGN_W-1:0] ea_low,
  output logic [NREG-1:0]    rd_mask,
  output logic               wr_lo_en,
  output logic [REG_W-1:0]   wr_lo_idx,
  output logic [CNT_W-1:0]   wr_lo_val,
  output logic               wr_hi_en,
  output logic [REG_W-1:0]   wr_hi_idx,
  output logic [CNT_W-1:0]   wr_hi_val,
  output logic               is_mem,
  output logic               is_dbl_ld,
  output logic [IC_W-1:0]    iss_cyc,
  output logic               enc_fault
);
  import ldd_pkg::*;

  op_e op;
  logic pair_op;
  logic misalign;
  logic odd_reg;
  logic [REG_W-1:0] pair_hi;

  assign op       = op_e'(op_raw);
  assign pair_op  = (op == OP_LDRD) || (op == OP_STRD);
  assign misalign = (ea_low != '0);
  assign odd_reg  = rd[0];
  assign pair_hi  = {rd[REG_W-1:1], 1'b1};
  assign enc_fault = pair_op && (misalign || odd_reg);

  always_comb begin
    rd_mask   = '0;
    wr_lo_en  = 1'b0;
    wr_lo_idx = rd;
    wr_lo_val = '0;
    wr_hi_en  = 1'b0;
    wr_hi_idx = pair_hi;
    wr_hi_val = '0;
    is_mem    = 1'b0;
    is_dbl_ld = 1'b0;
    iss_cyc   = IC_W'(1);
    if (op != OP_NOP) begin
      if (src_a_en) rd_mask[src_a] = 1'b1;
      if (src_b_en) rd_mask[src_b] = 1'b1;
    end
    unique case (op)
      OP_LDR: begin
        is_mem    = 1'b1;
        wr_lo_en  = 1'b1;
        wr_lo_val = CNT_W'(LAT_SINGLE - 1);
      end
      OP_STR: begin
        is_mem      = 1'b1;
        rd_mask[rd] = 1'b1;
      end
      OP_LDRD: begin
        is_mem    = 1'b1;
        is_dbl_ld = 1'b1;
        wr_lo_en  = 1'b1;
        wr_lo_val = CNT_W'(LAT_EVEN - 1);
        wr_hi_en  = 1'b1;
        wr_hi_val = CNT_W'(LAT_ODD - 1);
        if (rd == REG_W'(WIDE_REG)) iss_cyc = IC_W'(2);
      end
      OP_STRD: begin
        is_mem           = 1'b1;
        rd_mask[rd]      = 1'b1;
        rd_mask[pair_hi] = 1'b1;
        iss_cyc          = IC_W'(2);
      end
      OP_LDM, OP_STM: begin
        is_mem  = 1'b1;
        iss_cyc = IC_W'(MULTI_CYC);
      end
      default: begin
        iss_cyc = IC_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/ldd_scoreboard.sv
`timescale 1ns/1ps
module ldd_scoreboard #(
  parameter int NREG  = 16,
  parameter int CNT_W = 3,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo_en,
  input  logic [REG_W-1:0] wr_lo_idx,
  input  logic [CNT_W-1:0] wr_lo_val,
  input  logic             wr_hi_en,
  input  logic [REG_W-1:0] wr_hi_idx,
  input  logic [CNT_W-1:0] wr_hi_val,
  input  logic             miss,
  input  logic             ld_done,
  output logic [NREG-1:0]  ready
);
  localparam logic [CNT_W-1:0] PEND = {CNT_W{1'b1}};

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             hit_lo;
    logic             hit_hi;
    logic             cnt_en;

    assign hit_lo = wr_lo_en && (wr_lo_idx == REG_W'(r));
    assign hit_hi = wr_hi_en && (wr_hi_idx == REG_W'(r));
    assign cnt_en = hit_lo || hit_hi || (cnt_q != '0);

    always_comb begin
      cnt_d = cnt_q;
      if (cnt_q == PEND) begin
        if (ld_done) cnt_d = '0;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end
      if (hit_lo) cnt_d = miss ? PEND : wr_lo_val;
      if (hit_hi) cnt_d = miss ? PEND : wr_hi_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign ready[r] = (cnt_q == '0);
  end
endmodule

// File: rtl/ldd_issue_ctrl.sv
`timescale 1ns/1ps
module ldd_issue_ctrl #(
  parameter int IC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            dep,
  input  logic            is_mem,
  input  logic            is_dbl_ld,
  input  logic            fault,
  input  logic [IC_W-1:0] iss_cyc,
  output logic            stall,
  output logic            accept
);
  logic [IC_W-1:0] busy_q;
  logic [IC_W-1:0] busy_d;
  logic            bubble_q;
  logic            bubble_d;
  logic            busy;
  logic            busy_en;

  assign busy   = (busy_q != '0);
  assign stall  = busy || (in_valid && (dep || (bubble_q && is_mem)));
  assign accept = in_valid && !stall && !fault;

  always_comb begin
    busy_d = busy_q;
    if (accept) begin
      busy_d = iss_cyc - IC_W'(1);
    end else if (busy) begin
      busy_d = busy_q - IC_W'(1);
    end
    bubble_d = accept && is_dbl_ld;
  end

  assign busy_en = accept || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      bubble_q <= 1'b0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      bubble_q <= bubble_d;
    end
  end
endmodule

// File: rtl/ldd_hazard_interlock.sv
`timescale 1ns/1ps
module ldd_hazard_interlock #(
  parameter int NREG        = 16,
  parameter int CNT_W       = 3,
  parameter int LAT_EVEN    = 3,
  parameter int LAT_ODD     = 4,
  parameter int LAT_SINGLE  = 3,
  parameter int WIDE_REG    = 12,
  parameter int MULTI_CYC   = 4,
  parameter int DWORD_BYTES = 8,
  localparam int REG_W      = $clog2(NREG),
  localparam int ALIGN_W    = $clog2(DWORD_BYTES),
  localparam int IC_W       = $clog2(MULTI_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         in_op,
  input  logic [REG_W-1:0]   in_rd,
  input  logic [REG_W-1:0]   in_src_a,
  input  logic               in_src_a_en,
  input  logic [REG_W-1:0]   in_src_b,
  input  logic               in_src_b_en,
  input  logic [ALIGN_W-1:0] in_ea_low,
  input  logic               in_dhit,
  input  logic               ld_done,
  output logic               stall,
  output logic [IC_W-1:0]    issue_cycles,
  output logic               fault
);
  logic [NREG-1:0]  rd_mask;
  logic [NREG-1:0]  ready;
  logic             wr_lo_en, wr_hi_en;
  logic [REG_W-1:0] wr_lo_idx, wr_hi_idx;
  logic [CNT_W-1:0] wr_lo_val, wr_hi_val;
  logic             is_mem, is_dbl_ld, enc_fault;
  logic [IC_W-1:0]  iss_cyc;
  logic             dep, accept;

  ldd_decode #(
    .NREG(NREG), .CNT_W(CNT_W), .LAT_EVEN(LAT_EVEN), .LAT_ODD(LAT_ODD),
    .LAT_SINGLE(LAT_SINGLE), .WIDE_REG(WIDE_REG), .MULTI_CYC(MULTI_CYC),
    .REG_W(REG_W), .ALIGN_W(ALIGN_W), .IC_W(IC_W)
  ) u_dec (
    .op_raw(in_op), .rd(in_rd), .src_a(in_src_a), .src_a_en(in_src_a_en),
    .src_b(in_src_b), .src_b_en(in_src_b_en), .ea_low(in_ea_low),
    .rd_mask(rd_mask), .wr_lo_en(wr_lo_en), .wr_lo_idx(wr_lo_idx),
    .wr_lo_val(wr_lo_val), .wr_hi_en(wr_hi_en), .wr_hi_idx(wr_hi_idx),
    .wr_hi_val(wr_hi_val), .is_mem(is_mem), .is_dbl_ld(is_dbl_ld),
    .iss_cyc(iss_cyc), .enc_fault(enc_fault)
  );

  assign fault        = in_valid && enc_fault;
  assign issue_cycles = in_valid ? iss_cyc : '0;
  assign dep          = |(rd_mask & ~ready);

  ldd_issue_ctrl #(.IC_W(IC_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dep(dep),
    .is_mem(is_mem), .is_dbl_ld(is_dbl_ld), .fault(fault),
    .iss_cyc(iss_cyc), .stall(stall), .accept(accept)
  );

  ldd_scoreboard #(.NREG(NREG), .CNT_W(CNT_W), .REG_W(REG_W)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .wr_lo_en(accept && wr_lo_en), .wr_lo_idx(wr_lo_idx), .wr_lo_val(wr_lo_val),
    .wr_hi_en(accept && wr_hi_en), .wr_hi_idx(wr_hi_idx), .wr_hi_val(wr_hi_val),
    .miss(!in_dhit), .ld_done(ld_done), .ready(ready)
  );
endmodule

// File: rtl/ldd_hazard_checker.sv
`timescale 1ns/1ps
module ldd_hazard_checker #(
  parameter int WIDE_REG = 12,
  parameter int REG_W    = 4,
  parameter int ALIGN_W  = 3,
  parameter int IC_W     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [2:0]         in_op,
  input logic [REG_W-1:0]   in_rd,
  input logic [REG_W-1:0]   in_src_a,
  input logic               in_src_a_en,
  input logic [ALIGN_W-1:0] in_ea_low,
  input logic               in_dhit,
  input logic               stall,
  input logic [IC_W-1:0]    issue_cycles,
  input logic               fault
);
  import ldd_pkg::*;

  logic taken, mem_now, pair_now;
  assign taken    = in_valid && !stall && !fault;
  assign mem_now  = in_valid && (in_op != OP_ALU) && (in_op != OP_NOP);
  assign pair_now = (in_op == OP_LDRD) || (in_op == OP_STRD);

  AST_ODD_HALF_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_op == OP_LDRD && in_dhit) |=>
      (!(in_valid && in_src_a_en && in_src_a == ($past(in_rd) | REG_W'(1))) || stall)); // R2

  AST_PORT_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_op == OP_LDRD) |=> (!mem_now || stall)); // R3

  AST_ALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_now && in_ea_low != '0) |-> fault); // R4

  AST_ODD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_now && in_rd[0]) |-> fault); // R5

  AST_SINGLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_now) |-> !fault); // R5

  AST_STORE_PAIR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_op == OP_STRD) |=> stall); // R6

  AST_IDLE_ZERO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (issue_cycles == '0 && !fault)); // R6

  AST_WIDE_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_op == OP_LDRD && in_rd == REG_W'(WIDE_REG)) |=> stall); // R7
endmodule

bind ldd_hazard_interlock ldd_hazard_checker #(
  .WIDE_REG(WIDE_REG), .REG_W(REG_W), .ALIGN_W(ALIGN_W), .IC_W(IC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd),
  .in_src_a(in_src_a), .in_src_a_en(in_src_a_en), .in_ea_low(in_ea_low),
  .in_dhit(in_dhit), .stall(stall), .issue_cycles(issue_cycles), .fault(fault)
);

// File: tb/ldd_hazard_interlock_bench.sv
`timescale 1ns/1ps
module ldd_hazard_interlock_bench;
  import ldd_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic       in_valid, in_src_a_en, in_src_b_en, in_dhit, ld_done;
  logic [2:0] in_op, in_ea_low;
  logic [3:0] in_rd, in_src_a, in_src_b;
  logic       stall, fault;
  logic [2:0] issue_cycles;

  ldd_hazard_interlock u_ldd_hazard_interlock (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd),
    .in_src_a(in_src_a), .in_src_a_en(in_src_a_en), .in_src_b(in_src_b),
    .in_src_b_en(in_src_b_en), .in_ea_low(in_ea_low), .in_dhit(in_dhit),
    .ld_done(ld_done), .stall(stall), .issue_cycles(issue_cycles), .fault(fault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int rdy_at[16];
  bit pend[16];
  int busy_end = 0;
  int bub_cyc = -1;
  string req = "R11";
  bit last_acc, last_flt;

  function automatic bit reg_ok(logic [3:0] r);
    return !pend[r] && (cyc >= rdy_at[r]);
  endfunction

  function automatic int exp_cycles(logic [2:0] op, logic [3:0] rd);
    case (op)
      3'd3: return (rd == 4'd12) ? 2 : 1;
      3'd4: return 2;
      3'd5, 3'd6: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string r, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL [%s] actual %0d expected %0d", r, got, exp);
    end
  endtask

  // one clock: compare at negedge+2, then advance the reference at posedge
  task automatic cycle();
    bit dep, mem, e_stall, e_flt, acc;
    int e_ic;
    #2;
    dep = 0;
    mem = in_valid && (in_op >= 3'd1) && (in_op <= 3'd6);
    if (in_valid && in_op != 3'd7) begin
      if (in_src_a_en && !reg_ok(in_src_a)) dep = 1;
      if (in_src_b_en && !reg_ok(in_src_b)) dep = 1;
      if ((in_op == 3'd2 || in_op == 3'd4) && !reg_ok(in_rd)) dep = 1;
      if (in_op == 3'd4 && !reg_ok({in_rd[3:1], 1'b1})) dep = 1;
    end
    e_ic    = in_valid ? exp_cycles(in_op, in_rd) : 0;
    e_flt   = in_valid && (in_op == 3'd3 || in_op == 3'd4) && (in_ea_low != 3'd0 || in_rd[0]);
    e_stall = (cyc < busy_end) || (in_valid && (dep || (bub_cyc == cyc && mem)));
    n_cmp++;
    if (stall !== e_stall || fault !== e_flt || int'(issue_cycles) != e_ic) begin
      n_bad++;
      $display("FAIL [%s] cycle %0d actual stall=%b fault=%b ic=%0d expected stall=%b fault=%b ic=%0d",
               req, cyc, stall, fault, issue_cycles, e_stall, e_flt, e_ic);
    end
    acc = in_valid && !e_stall && !e_flt;
    @(posedge clk);
    if (ld_done) begin
      for (int r = 0; r < 16; r++) if (pend[r]) begin pend[r] = 0; rdy_at[r] = cyc + 1; end
    end
    if (acc) begin
      if (in_op == 3'd1) begin
        if (in_dhit) rdy_at[in_rd] = cyc + 3; else pend[in_rd] = 1;
      end
      if (in_op == 3'd3) begin
        if (in_dhit) begin
          rdy_at[in_rd] = cyc + 3;
          rdy_at[{in_rd[3:1], 1'b1}] = cyc + 4;
        end else begin
          pend[in_rd] = 1;
          pend[{in_rd[3:1], 1'b1}] = 1;
        end
        bub_cyc = cyc + 1;
      end
      busy_end = cyc + e_ic;
    end
    cyc++;
    last_acc = acc;
    last_flt = e_flt;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] rd, input logic [3:0] sa,
                       input bit sae, input logic [3:0] sb, input bit sbe,
                       input logic [2:0] ea, input bit hit, output int stalls, output bit flt);
    in_valid = 1; in_op = op; in_rd = rd; in_src_a = sa; in_src_a_en = sae;
    in_src_b = sb; in_src_b_en = sbe; in_ea_low = ea; in_dhit = hit;
    stalls = 0;
    for (int k = 0; k < 40; k++) begin
      cycle();
      if (last_acc || last_flt) break;
      stalls++;
    end
    flt = last_flt;
    in_valid = 0;
  endtask

  task automatic idle(int n);
    in_valid = 0;
    for (int k = 0; k < n; k++) cycle();
  endtask

  int s;
  bit f;

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL [R11] watchdog expired: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) begin rdy_at[r] = 0; pend[r] = 0; end
    rst_n = 0; in_valid = 0; in_op = 0; in_rd = 0; in_src_a = 0; in_src_b = 0;
    in_src_a_en = 0; in_src_b_en = 0; in_ea_low = 0; in_dhit = 1; ld_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    req = "R11"; idle(2);
    issue(OP_ALU, 0, 1, 1, 2, 1, 0, 1, s, f); chk("R11", s, 0);

    req = "R1"; idle(6);
    issue(OP_LDRD, 2, 11, 1, 0, 0, 0, 1, s, f); chk("R1", s, 0);
    issue(OP_ALU, 0, 2, 1, 0, 0, 0, 1, s, f);  chk("R1", s, 2);

    req = "R2"; idle(6);
    issue(OP_LDRD, 0, 11, 1, 0, 0, 0, 1, s, f); chk("R2", s, 0);
    issue(OP_ALU, 5, 1, 1, 0, 0, 0, 1, s, f);   chk("R2", s, 3);
    idle(6);
    issue(OP_LDRD, 14, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_ALU, 5, 3, 0, 15, 1, 0, 1, s, f);  chk("R2", s, 3);

    req = "R3"; idle(6);
    issue(OP_LDRD, 4, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_ALU, 6, 9, 1, 8, 1, 0, 1, s, f);   chk("R3", s, 0);
    idle(6);
    issue(OP_LDRD, 4, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_STR, 10, 11, 1, 0, 0, 0, 1, s, f); chk("R3", s, 1);
    idle(6);
    issue(OP_LDRD, 4, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_LDR, 7, 11, 1, 0, 0, 0, 1, s, f);  chk("R3", s, 1);

    req = "R7"; idle(6);
    issue(OP_LDRD, 12, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_ALU, 6, 0, 1, 0, 0, 0, 1, s, f);   chk("R7", s, 1);

    req = "R12"; idle(6);
    issue(OP_LDRD, 12, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_LDR, 7, 11, 1, 0, 0, 0, 1, s, f);  chk("R12", s, 1);

    req = "R6"; idle(6);
    issue(OP_STRD, 6, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_ALU, 8, 0, 1, 0, 0, 0, 1, s, f);   chk("R6", s, 1);
    issue(OP_LDM, 0, 1, 1, 0, 0, 0, 1, s, f);
    issue(OP_ALU, 8, 0, 1, 0, 0, 0, 1, s, f);   chk("R6", s, 3);
    issue(OP_STM, 0, 1, 1, 0, 0, 0, 1, s, f);
    issue(OP_NOP, 0, 0, 0, 0, 0, 0, 1, s, f);   chk("R6", s, 3);

    req = "R4"; idle(6);
    issue(OP_LDRD, 0, 11, 1, 0, 0, 3'd4, 1, s, f); chk("R4", int'(f), 1);
    issue(OP_LDR, 7, 1, 1, 0, 0, 0, 1, s, f);      chk("R4", s, 0);

    req = "R5"; idle(6);
    issue(OP_STRD, 3, 11, 1, 0, 0, 0, 1, s, f);    chk("R5", int'(f), 1);
    issue(OP_LDRD, 5, 11, 1, 0, 0, 0, 1, s, f);    chk("R5", int'(f), 1);
    issue(OP_ALU, 8, 5, 1, 0, 0, 0, 1, s, f);      chk("R5", s, 0);
    issue(OP_STR, 9, 11, 1, 0, 0, 3'd2, 1, s, f);  chk("R5", int'(f), 0);

    req = "R8"; idle(6);
    issue(OP_LDRD, 8, 11, 1, 0, 0, 0, 0, s, f);
    fork
      issue(OP_ALU, 6, 9, 1, 0, 0, 0, 1, s, f);
      begin
        repeat (5) @(posedge clk);
        #1 ld_done = 1;
        @(posedge clk);
        #1 ld_done = 0;
      end
    join
    chk("R8", s, 6);
    issue(OP_ALU, 6, 8, 1, 0, 0, 0, 1, s, f);   chk("R8", s, 0);

    req = "R10"; idle(6);
    issue(OP_LDR, 5, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_ALU, 6, 5, 1, 0, 0, 0, 1, s, f);   chk("R10", s, 2);

    req = "R9"; idle(6);
    issue(OP_LDR, 5, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_STR, 5, 11, 1, 0, 0, 0, 1, s, f);  chk("R9", s, 2);
    idle(6);
    issue(OP_LDRD, 0, 11, 1, 0, 0, 0, 1, s, f);
    issue(OP_STRD, 0, 11, 1, 0, 0, 0, 1, s, f); chk("R9", s, 3);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule